// File: doc/BRIEF.md
# I2S Master Bit-Clock, Word-Select and Serial-Data Generator

This block is the transmit timing core of an I2S master. From a fast reference clock it makes a continuous serial bit clock with an 8-bit programmable divider, a word-select line that marks the left and right channel slots, and a serial data line that carries a left and a right sample word per frame. The sample words come in through a simple load port. A request strobe asks for the next pair once per frame. If no pair arrives in time, an underrun strobe is raised and the previous pair is sent again.

Two frame shapes are available. In symmetric mode a frame is exactly two channel words long, so word select has a 50% duty cycle. In accurate mode the frame length is programmed on its own, up to 4096 bit clocks. The two channel words go out first. The remaining bit clocks are idle padding: the bit clock keeps running, word select stays high and data stays low. Padding lets software pick a bit-clock divider that matches the target sample rate more closely, at the cost of an asymmetric word select. All configuration is taken into use only at frame boundaries.

Top module: `i2s_master_fgen`

## Requirements
- R1: While `rst` is high, or while `en` is low, `bclk_o` is 0, `ws_o` is 1 and `sd_o` is 0. These values appear from the first reference edge that sees the condition.
- R2: With d = `clk_div`, or d = 1 when `clk_div` is 0, one bit-clock period lasts d+1 reference cycles. Of these, floor((d+1)/2) are high, and the low phase comes first.
- R3: In symmetric mode (`accurate_mode` = 0) a frame lasts 2·W bit clocks, where W = `word_len_m1`+1. `ws_o` is 0 for the first W bit clocks and 1 for the next W.
- R4: Data is sent MSB first and changes only on falling bit-clock edges. Bit 15 of the left word appears one bit clock after `ws_o` falls, and the right word follows directly after the left. Only the top W bits of each 16-bit load word are sent.
- R5: In accurate mode a frame lasts `frame_per`+1 bit clocks. `ws_o` is 0 for the first W of them and 1 for the rest. After the right word's last bit, every remaining bit clock of the frame has `sd_o` at 0 while `bclk_o` keeps toggling.
- R6: In accurate mode, if `frame_per`+1 is less than 2·W, the frame lasts 2·W bit clocks, as in symmetric mode.
- R7: The configuration inputs are sampled when the block is enabled and at each frame boundary. A change during a frame does not alter that frame's length or shape.
- R8: `req_o` pulses high for exactly one reference cycle once per frame, when the held pair is taken for transmission. A word pair presented with `ld_valid` before the next such take-over is used in the following frame.
- R9: If no pair was loaded since the last take-over, `underrun_o` pulses together with `req_o`, and the previously sent pair is sent again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low forces the idle line state |
| accurate_mode | input | 1 | 1 = padded frames of programmable length, 0 = two-word frames |
| clk_div | input | 8 | Bit-clock divider value d (period d+1 reference cycles) |
| frame_per | input | 12 | Frame length minus one, in bit clocks (accurate mode) |
| word_len_m1 | input | 4 | Channel word length in bits minus one |
| ld_valid | input | 1 | Load strobe for the next sample pair |
| ld_left | input | 16 | Left sample, MSB-justified |
| ld_right | input | 16 | Right sample, MSB-justified |
| bclk_o | output | 1 | Serial bit clock |
| ws_o | output | 1 | Word select, 0 = left slot |
| sd_o | output | 1 | Serial transmit data |
| req_o | output | 1 | One-cycle request for the next pair |
| underrun_o | output | 1 | One-cycle strobe: no new pair, previous pair repeated |

## Verification
The in-line properties assume that `en` stays high for the whole run they observe, and that the divider always gives a bit-clock period of at least two reference cycles. The block itself enforces the second point by treating a zero divider as one. The edge-alignment properties also expect `word_len_m1` to describe a word no wider than the 16-bit load bus. The bench changes configuration only while `en` is low, except in the one scenario that deliberately changes the frame shape in mid-frame. It drives all inputs on the falling reference edge and decodes the lines the way a receiver would, sampling on rising bit-clock edges.

// File: rtl/i2sfg_pkg.sv
package i2sfg_pkg;

    localparam int DIV_W  = 8;
    localparam int FPER_W = 12;
    localparam int WORD_W = 16;               // power of two
    localparam int FW_W   = $clog2(WORD_W);
    localparam int LEN_W  = FPER_W + 1;

    typedef struct packed {
        logic              accurate;
        logic [DIV_W-1:0]  div;
        logic [FPER_W-1:0] fper;
        logic [FW_W-1:0]   fwid;
    } cfg_t;

    typedef struct packed {
        logic [WORD_W-1:0] left;
        logic [WORD_W-1:0] right;
    } pair_t;

    function automatic logic [LEN_W-1:0] word_bits(input cfg_t c);
        return LEN_W'(c.fwid) + LEN_W'(1);
    endfunction

    function automatic logic [LEN_W-1:0] frame_len(input cfg_t c);
        logic [LEN_W-1:0] two_w;
        logic [LEN_W-1:0] prog;
        two_w = word_bits(c) << 1;
        prog  = LEN_W'(c.fper) + LEN_W'(1);
        return (c.accurate && (prog > two_w)) ? prog : two_w;
    endfunction

    function automatic logic [DIV_W-1:0] eff_div(input logic [DIV_W-1:0] d);
        return (d == '0) ? DIV_W'(1) : d;
    endfunction

endpackage

// File: rtl/i2sfg_clkdiv.sv
module i2sfg_clkdiv
    import i2sfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             run,
    input  logic [DIV_W-1:0] div_q,
    output logic             bclk,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] dd;
    logic [DIV_W:0]   per;
    logic [DIV_W:0]   hi_len;
    logic [DIV_W:0]   lo_len;

    always_comb begin
        dd     = eff_div(div_q);
        per    = {1'b0, dd} + 1'b1;
        hi_len = per >> 1;
        lo_len = per - hi_len;
    end

    assign tick = run && (cnt >= dd);

    always_ff @(posedge clk) begin
        if (rst || !en || !run) begin
            cnt  <= '0;
            bclk <= 1'b0;
        end else if (tick) begin
            cnt  <= '0;
            bclk <= 1'b0;
        end else begin
            cnt  <= cnt + 1'b1;
            bclk <= (({1'b0, cnt} + 1'b1) >= lo_len);
        end
    end

    // R2
    tick_fall_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !bclk);

endmodule

// File: rtl/i2sfg_pair.sv
module i2sfg_pair
    import i2sfg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ld_v,
    input  pair_t ld_pair,
    input  logic  consume,
    output pair_t pair_use,
    output logic  req,
    output logic  underrun
);
    pair_t hold_q;
    pair_t cur_q;
    logic  full_q;

    assign pair_use = (consume && full_q) ? hold_q : cur_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q   <= '0;
            cur_q    <= '0;
            full_q   <= 1'b0;
            req      <= 1'b0;
            underrun <= 1'b0;
        end else begin
            req      <= consume;
            underrun <= consume && !full_q;
            if (consume && full_q)
                cur_q <= hold_q;
            if (ld_v) begin
                hold_q <= ld_pair;
                full_q <= 1'b1;
            end else if (consume) begin
                full_q <= 1'b0;
            end
        end
    end

    // R8
    req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        req |=> !req);

    // R9
    repeat_pair_chk: assert property (@(posedge clk) disable iff (rst)
        underrun |-> $stable(cur_q));

endmodule

// File: rtl/i2sfg_frame.sv
module i2sfg_frame
    import i2sfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             run,
    input  logic             tick,
    input  cfg_t             cfg_in,
    input  pair_t            pair_use,
    output logic [DIV_W-1:0] div_q,
    output logic             consume,
    output logic             ws,
    output logic             sd
);
    cfg_t              cfg_q;
    logic [FPER_W-1:0] b_q;
    logic [FPER_W-1:0] b_nxt;
    logic [LEN_W-1:0]  plen;
    logic [LEN_W-1:0]  wlen;
    logic [LEN_W-1:0]  p;
    logic [FW_W-1:0]   pos;
    logic              last;
    logic              bit_nxt;
    logic              ws_nxt;

    assign div_q = cfg_q.div;

    always_comb begin
        plen  = frame_len(cfg_q);
        wlen  = word_bits(cfg_q);
        last  = (LEN_W'(b_q) == (plen - LEN_W'(1)));
        b_nxt = last ? '0 : b_q + FPER_W'(1);
        p     = (b_nxt == '0) ? (plen - LEN_W'(1)) : (LEN_W'(b_nxt) - LEN_W'(1));
        pos   = '0;
        bit_nxt = 1'b0;
        if (p < wlen) begin
            pos     = FW_W'(p);
            bit_nxt = pair_use.left[~pos];
        end else if (p < (wlen << 1)) begin
            pos     = FW_W'(p - wlen);
            bit_nxt = pair_use.right[~pos];
        end
        ws_nxt = !(LEN_W'(b_nxt) < wlen);
    end

    assign consume = tick && (b_nxt == FPER_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            b_q   <= '0;
            ws    <= 1'b1;
            sd    <= 1'b0;
        end else if (!en) begin
            b_q <= '0;
            ws  <= 1'b1;
            sd  <= 1'b0;
        end else if (!run) begin
            cfg_q <= cfg_in;
            b_q   <= '0;
            ws    <= 1'b0;
            sd    <= 1'b0;
        end else if (tick) begin
            b_q <= b_nxt;
            ws  <= ws_nxt;
            sd  <= bit_nxt;
            if (last)
                cfg_q <= cfg_in;
        end
    end

    logic run_d;
    always_ff @(posedge clk) begin
        if (rst) run_d <= 1'b0;
        else     run_d <= run;
    end

    // R7
    cfg_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        (run && run_d && (cfg_q != $past(cfg_q))) |-> (b_q == '0));

endmodule

// File: rtl/i2s_master_fgen.sv
module i2s_master_fgen
    import i2sfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              accurate_mode,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic [FPER_W-1:0] frame_per,
    input  logic [FW_W-1:0]   word_len_m1,
    input  logic              ld_valid,
    input  logic [WORD_W-1:0] ld_left,
    input  logic [WORD_W-1:0] ld_right,
    output logic              bclk_o,
    output logic              ws_o,
    output logic              sd_o,
    output logic              req_o,
    output logic              underrun_o
);
    logic             run_q;
    logic             tick;
    logic             consume;
    logic [DIV_W-1:0] div_q;
    cfg_t             cfg_in;
    pair_t            ld_pair;
    pair_t            pair_use;

    always_ff @(posedge clk) begin
        if (rst) run_q <= 1'b0;
        else     run_q <= en;
    end

    always_comb begin
        cfg_in.accurate = accurate_mode;
        cfg_in.div      = clk_div;
        cfg_in.fper     = frame_per;
        cfg_in.fwid     = word_len_m1;
        ld_pair.left    = ld_left;
        ld_pair.right   = ld_right;
    end

    i2sfg_clkdiv u_div (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .run   (run_q),
        .div_q (div_q),
        .bclk  (bclk_o),
        .tick  (tick)
    );

    i2sfg_frame u_frame (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .run      (run_q),
        .tick     (tick),
        .cfg_in   (cfg_in),
        .pair_use (pair_use),
        .div_q    (div_q),
        .consume  (consume),
        .ws       (ws_o),
        .sd       (sd_o)
    );

    i2sfg_pair u_pair (
        .clk      (clk),
        .rst      (rst),
        .ld_v     (ld_valid),
        .ld_pair  (ld_pair),
        .consume  (consume),
        .pair_use (pair_use),
        .req      (req_o),
        .underrun (underrun_o)
    );

    // R1
    idle_line_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!bclk_o && ws_o && !sd_o));

    // R4
    ws_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (run_q && $past(run_q) && (ws_o != $past(ws_o))) |-> $fell(bclk_o));

    // R4
    sd_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (run_q && $past(run_q) && (sd_o != $past(sd_o))) |-> $fell(bclk_o));

endmodule

// File: tb/sim_i2s_master_fgen.sv
`timescale 1ns/1ps
module sim_i2s_master_fgen;
    localparam int CAP = 16384;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        acc = 1'b0;
    logic [7:0]  div = 8'd1;
    logic [11:0] fper = 12'd0;
    logic [3:0]  fwid = 4'd15;
    logic        ld_valid = 1'b0;
    logic [15:0] ld_left = '0;
    logic [15:0] ld_right = '0;
    logic        bclk, ws, sd, req, und;

    logic        feed_on = 1'b0;
    logic        pre_ld = 1'b0;
    logic [15:0] feed_l = '0;
    logic [15:0] feed_r = '0;

    int n_chk = 0;
    int n_fail = 0;
    int st = 0;

    always #2.5 clk = ~clk;

    i2s_master_fgen u0 (
        .clk(clk), .rst(rst), .en(en), .accurate_mode(acc), .clk_div(div),
        .frame_per(fper), .word_len_m1(fwid), .ld_valid(ld_valid),
        .ld_left(ld_left), .ld_right(ld_right), .bclk_o(bclk), .ws_o(ws),
        .sd_o(sd), .req_o(req), .underrun_o(und)
    );

    // pair feeder
    always @(negedge clk) begin
        ld_valid <= pre_ld || (feed_on && req);
        ld_left  <= feed_l;
        ld_right <= feed_r;
    end

    // receiver-style capture on rising bit-clock edges
    logic ws_c [CAP];
    logic sd_c [CAP];
    int   per_c [CAP];
    int   hi_c [CAP];
    int   rq_c [CAP];
    int   ur_c [CAP];
    int   cap_n = 0;
    int   cyc = 0;
    int   hic = 0;
    int   rq_n = 0;
    int   ur_n = 0;
    logic prev_b = 1'b0;

    always @(negedge clk) begin
        if (req) rq_n <= rq_n + 1;
        if (und) ur_n <= ur_n + 1;
        if (bclk && !prev_b) begin
            if (cap_n < CAP) begin
                ws_c[cap_n]  <= ws;
                sd_c[cap_n]  <= sd;
                per_c[cap_n] <= cyc;
                hi_c[cap_n]  <= hic;
                rq_c[cap_n]  <= rq_n;
                ur_c[cap_n]  <= ur_n;
            end
            cap_n <= cap_n + 1;
            cyc   <= 1;
            hic   <= 1;
        end else begin
            cyc <= cyc + 1;
            hic <= hic + (bclk ? 1 : 0);
        end
        prev_b <= bclk;
    end

    int wd = 0;
    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd == 150000) begin
            n_chk  = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog: got %0d cycles expected fewer", wd);
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s %s: got %0d expected %0d", rq, what, act, exp);
        end
    endtask

    function automatic int find_fall(input int from);
        for (int i = from; i < cap_n && i < CAP; i++)
            if (i >= 1 && ws_c[i-1] && !ws_c[i]) return i;
        return -1;
    endfunction

    task automatic wait_bits(input int n);
        while (cap_n < st + n) @(negedge clk);
    endtask

    task automatic start_run(input logic a, input logic [7:0] d, input logic [11:0] fp,
                             input logic [3:0] fw, input logic [15:0] l,
                             input logic [15:0] r, input logic feed);
        @(negedge clk);
        en = 1'b0;
        acc = a; div = d; fper = fp; fwid = fw;
        feed_l = l; feed_r = r; feed_on = feed;
        pre_ld = 1'b1;
        @(negedge clk);
        pre_ld = 1'b0;
        @(negedge clk);
        @(negedge clk);
        st = cap_n;
        en = 1'b1;
    endtask

    task automatic stop_run();
        @(negedge clk);
        en = 1'b0;
        feed_on = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // decode one steady-state frame and check it
    task automatic check_frame(input string rlen, input int w, input int exp_len,
                               input logic [15:0] el, input logic [15:0] er,
                               input int deff, input int exp_und);
        int f1, f2, lows, dbad, pbad, hbad;
        logic [15:0] gl, gr;
        wait_bits(3 * exp_len + 8);
        f1 = find_fall(st + 1);
        f2 = (f1 < 0) ? -1 : find_fall(f1 + 1);
        chk(f1 > 0 && f2 > 0, rlen, "two word-select falls found", f2, 1);
        if (f1 <= 0 || f2 <= 0) return;
        chk(f2 - f1 == exp_len, rlen, "frame length in bit clocks", f2 - f1, exp_len);
        lows = 0;
        for (int k = f1; k < f2; k++) if (!ws_c[k]) lows++;
        chk(lows == w, rlen, "ws low bit clocks", lows, w);
        gl = '0; gr = '0;
        for (int j = 0; j < w; j++) begin
            gl = {gl[14:0], sd_c[f1 + 1 + j]};
            gr = {gr[14:0], sd_c[f1 + 1 + w + j]};
        end
        chk(gl == (el >> (16 - w)), "R4", "left word", gl, el >> (16 - w));
        chk(gr == (er >> (16 - w)), "R4", "right word", gr, er >> (16 - w));
        dbad = 0;
        for (int k = f1 + 2 * w + 1; k < f2; k++) if (sd_c[k]) dbad++;
        chk(dbad == 0, "R5", "padding bits high", dbad, 0);
        pbad = 0; hbad = 0;
        for (int k = f1 + 1; k <= f2; k++) begin
            if (per_c[k] != deff + 1) pbad++;
            if (hi_c[k] != (deff + 1) / 2) hbad++;
        end
        chk(pbad == 0, "R2", "bit periods off", pbad, 0);
        chk(hbad == 0, "R2", "high phases off", hbad, 0);
        chk(rq_c[f2] - rq_c[f1] == 1, "R8", "requests per frame", rq_c[f2] - rq_c[f1], 1);
        chk(ur_c[f2] - ur_c[f1] == exp_und, "R9", "underruns per frame",
            ur_c[f2] - ur_c[f1], exp_und);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        chk(bclk == 1'b0, "R1", "bclk in reset", bclk, 0);
        chk(ws == 1'b1, "R1", "ws in reset", ws, 1);
        chk(sd == 1'b0, "R1", "sd in reset", sd, 0);
        chk(req == 1'b0 && und == 1'b0, "R8", "strobes in reset", req | und, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(bclk == 1'b0 && ws == 1'b1, "R1", "idle with en low", {bclk, ws}, 1);
    endtask

    task automatic t_sym16();   // R3
        start_run(1'b0, 8'd3, 12'd100, 4'd15, 16'hA5C3, 16'h3C96, 1'b1);
        check_frame("R3", 16, 32, 16'hA5C3, 16'h3C96, 3, 0);
        stop_run();
    endtask

    task automatic t_sym8_div0();   // R3, R2 with zero divider
        start_run(1'b0, 8'd0, 12'd0, 4'd7, 16'hB7FF, 16'h4E00, 1'b1);
        check_frame("R3", 8, 16, 16'hB7FF, 16'h4E00, 1, 0);
        stop_run();
    endtask

    task automatic t_accurate();   // R5
        start_run(1'b1, 8'd4, 12'd39, 4'd15, 16'h8001, 16'hF00D, 1'b1);
        check_frame("R5", 16, 40, 16'h8001, 16'hF00D, 4, 0);
        stop_run();
    endtask

    task automatic t_clamp();   // R6
        start_run(1'b1, 8'd1, 12'd20, 4'd15, 16'h1234, 16'hFEDC, 1'b1);
        check_frame("R6", 16, 32, 16'h1234, 16'hFEDC, 1, 0);
        stop_run();
    endtask

    task automatic t_underrun();   // R9
        start_run(1'b1, 8'd2, 12'd35, 4'd15, 16'hC0DE, 16'h0BAD, 1'b0);
        check_frame("R9", 16, 36, 16'hC0DE, 16'h0BAD, 2, 1);
        stop_run();
    endtask

    task automatic t_cfg_change();   // R7
        int f, g, n32, n41, bad;
        start_run(1'b0, 8'd1, 12'd0, 4'd15, 16'h6A6A, 16'h9595, 1'b1);
        wait_bits(45);
        @(negedge clk);
        acc = 1'b1; fper = 12'd40;
        wait_bits(300);
        n32 = 0; n41 = 0; bad = 0;
        f = find_fall(st + 1);
        while (f > 0) begin
            g = find_fall(f + 1);
            if (g < 0) break;
            if (g - f == 32) n32++;
            else if (g - f == 41) n41++;
            else bad++;
            f = g;
        end
        chk(bad == 0, "R7", "frames of mixed length", bad, 0);
        chk(n32 > 0, "R7", "old-shape frames seen", n32, 1);
        chk(n41 > 0, "R7", "new-shape frames seen", n41, 1);
        // R1: disable returns the lines to idle at once
        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        chk(bclk == 1'b0 && ws == 1'b1 && sd == 1'b0, "R1", "idle after disable",
            {bclk, ws, sd}, 3'b010);
        feed_on = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_sym16();
        t_sym8_div0();
        t_accurate();
        t_clamp();
        t_underrun();
        t_cfg_change();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule